// File: doc/BRIEF.md
# I2C Target Write Receiver with Per-Byte Acknowledge Hold

This block is the receive side of an I2C target (slave) for 7-bit addressing. It accepts write transfers only. The SCL and SDA pins are oversampled on a fast system clock, which must run at least eight times the SCL rate. The block finds Start and Stop conditions on the bus and compares the first byte after a Start with a configured 7-bit address. It then shifts in the data bytes that follow. For each byte it can drive SDA low as the acknowledge, and it can hold SCL low to stretch the clock while software catches up.

Software works through a small set of register-like signals:

- a receive buffer with a full flag, which is cleared by reading the buffer;
- a sticky overflow flag;
- a sticky interrupt flag;
- a clock-release bit, which hardware clears and only software sets;
- an acknowledge-value input;
- status bits for Start seen, Stop seen and acknowledge time.

Three enables change the flow. Stretch mode holds SCL after each acknowledged byte. Address hold and data hold each pause the bus after the eighth falling SCL edge of that kind of byte. While the bus is paused, software decides ACK or NACK before the ninth clock.

The bus pins are open-drain. The block only drives separate pull-low enables, and the pad or the bench combines those with the bus.

Top module: `i2c_tgt_rx`

## Requirements
- R1: A Start condition (SDA falling while SCL is high) sets start_seen and clears stop_seen. A Stop condition (SDA rising while SCL is high) sets stop_seen, clears start_seen and returns the receiver to idle.
- R2: A first byte after a Start is accepted when its upper seven bits equal own_addr and its last bit (R/W) is 0. For an accepted byte, SDA is pulled low on the ninth clock (ACK), the byte {address, R/W} is placed in rx_buf and buf_full is set.
- R3: A first byte that does not match own_addr, or that has R/W = 1, gets no ACK (SDA stays released). Nothing is stored and irq is not raised. Later bytes also get no ACK until the next Start.
- R4: Each data byte after an accepted address is ACKed and loaded into rx_buf, and irq is set after the ninth falling SCL edge.
- R5: A byte that completes while buf_full or ovf is set is answered with NACK, and rx_buf keeps its old value.
- R6: ovf is set when a byte completes while buf_full is set. ovf stays set until an ovf_clr pulse, and reading the buffer does not clear it.
- R7: irq, once set, stays set until an irq_clr pulse.
- R8: A rd_buf pulse clears buf_full and leaves rx_buf unchanged.
- R9: With stretch_en = 1, after the ACK of each byte the block clears ckp and holds SCL low until software pulses rel_set.
- R10: With addr_hold_en (for the address byte) or data_hold_en (for data bytes), after the eighth falling SCL edge the block sets irq, sets ack_time, clears ckp, loads the byte and holds SCL low.
- R11: In a hold, the ninth clock carries the value of ack_nack (0 = ACK, 1 = NACK) as sampled when rel_set releases SCL. ack_time returns to 0 at the ninth falling edge.
- R12: When a NACK is sent, irq is not set at the ninth falling edge.
- R13: With start_irq_en, a Start sets irq. With stop_irq_en, a Stop sets irq. With both enables at 0, neither condition raises irq.
- R14: ckp is 1 after reset, only hardware clears it, and it returns to 1 only on a rel_set pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK) |
| own_addr | input | 7 | Target address |
| stretch_en | input | 1 | Stretch SCL after each ACK |
| addr_hold_en | input | 1 | Pause before the ACK of the address byte |
| data_hold_en | input | 1 | Pause before the ACK of data bytes |
| start_irq_en | input | 1 | Start raises irq |
| stop_irq_en | input | 1 | Stop raises irq |
| ack_nack | input | 1 | ACK value used in a hold: 0 = ACK, 1 = NACK |
| rel_set | input | 1 | Pulse: set ckp and release SCL |
| rd_buf | input | 1 | Pulse: software read of rx_buf |
| irq_clr | input | 1 | Pulse: clear irq |
| ovf_clr | input | 1 | Pulse: clear ovf |
| rx_buf | output | 8 | Last received byte |
| buf_full | output | 1 | rx_buf holds an unread byte |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt flag |
| ckp | output | 1 | Clock-release bit |
| ack_time | output | 1 | Current interrupt came before the ACK |
| start_seen | output | 1 | Start was the last bus condition |
| stop_seen | output | 1 | Stop was the last bus condition |

## Verification
The assertions check on every cycle that:

- irq and ovf keep their value until their clear pulses arrive;
- buf_full falls only after a read;
- ovf rises only while the buffer is full;
- ckp returns to 1 only after rel_set;
- the SDA pull-down changes only while SCL is low.

Address matching, ACK versus NACK on the ninth clock, the exact point at which SCL is held in each hold mode, and the ack_time sequence all depend on whole bus transactions. Only the bench's directed scenarios, which drive a bit-level controller model, can show those.

// File: rtl/i2c_rx_pkg.sv
// Shared types for the I2C target receiver.
package i2c_rx_pkg;
    // Receiver phase within a transfer.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_DATA,
        RX_HOLD,
        RX_ACK
    } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizer and edge detector for one bus line.
// Assumes the line idles high. The output is delayed by STAGES clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the flop chain and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/i2c_rx_engine.sv
// Bit-level receive engine: Start/Stop detection, shift register,
// address match, ACK decision, SCL hold and the clock-release bit.
// Assumes synchronized inputs and SDA changes only while SCL is low,
// except for Start and Stop conditions.
module i2c_rx_engine
    import i2c_rx_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              addr_hold_en,
    input  logic              data_hold_en,
    input  logic              ack_nack,
    input  logic              rel_set,
    input  logic              buf_full,
    input  logic              ovf,
    output logic              start_det,
    output logic              stop_det,
    output logic              load,
    output logic [ADDR_W:0]   load_val,
    output logic              ovf_set,
    output logic              irq_set,
    output logic              ckp,
    output logic              ack_time,
    output logic              scl_low,
    output logic              sda_low
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              is_addr;
    logic              ack_go;
    logic              blocked;
    logic              hold_req;

    logic addr_ok, busy, in_byte, byte_end, complete, hold_sel, ack_end;

    // Bus condition detection and byte-end decode.
    always_comb begin
        start_det = sda_fall & scl_s;
        stop_det  = sda_rise & scl_s;
        addr_ok   = (shreg[BYTE_W-1:1] == own_addr) && !shreg[0];
        busy      = buf_full | ovf;
        in_byte   = (state == RX_ADDR) || (state == RX_DATA);
        byte_end  = in_byte && scl_fall && (cnt == CNT_FULL) && !start_det && !stop_det;
        complete  = byte_end && (!is_addr || addr_ok);
        hold_sel  = is_addr ? addr_hold_en : data_hold_en;
        ack_end   = (state == RX_ACK) && scl_fall && !start_det && !stop_det;
        load      = complete && !busy;
        load_val  = shreg;
        ovf_set   = complete && buf_full;
        irq_set   = (complete && hold_sel) || (ack_end && ack_go);
        scl_low   = hold_req && !ckp;
        sda_low   = (state == RX_ACK) && ack_go;
    end

    // Transfer sequencing, hold control and clock-release bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            is_addr  <= 1'b0;
            ack_go   <= 1'b0;
            blocked  <= 1'b0;
            hold_req <= 1'b0;
            ckp      <= 1'b1;
            ack_time <= 1'b0;
        end else begin
            if (rel_set)
                ckp <= 1'b1;
            if (hold_req && ckp)
                hold_req <= 1'b0;
            if (start_det) begin
                state    <= RX_ADDR;
                cnt      <= '0;
                is_addr  <= 1'b1;
                hold_req <= 1'b0;
                ack_time <= 1'b0;
            end else if (stop_det) begin
                state    <= RX_IDLE;
                hold_req <= 1'b0;
                ack_time <= 1'b0;
            end else begin
                case (state)
                    RX_ADDR, RX_DATA: begin
                        if (scl_rise && cnt != CNT_FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (byte_end) begin
                            if (!complete) begin
                                state <= RX_IDLE;
                            end else if (hold_sel) begin
                                ckp      <= 1'b0;
                                hold_req <= 1'b1;
                                ack_time <= 1'b1;
                                blocked  <= busy;
                                state    <= RX_HOLD;
                            end else begin
                                ack_go <= !busy;
                                state  <= RX_ACK;
                            end
                        end
                    end
                    RX_HOLD: begin
                        if (ckp) begin
                            ack_go <= !blocked && !ack_nack;
                            state  <= RX_ACK;
                        end
                    end
                    RX_ACK: begin
                        if (ack_end) begin
                            ack_time <= 1'b0;
                            cnt      <= '0;
                            is_addr  <= 1'b0;
                            if (ack_go) begin
                                state <= RX_DATA;
                                if (stretch_en) begin
                                    ckp      <= 1'b0;
                                    hold_req <= 1'b1;
                                end
                            end else begin
                                state <= RX_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_rx_regs.sv
// Software-visible flags: receive buffer, full, overflow, interrupt and
// bus-condition status. Hardware set events win over software clears.
module i2c_rx_regs #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              ovf_set,
    input  logic              irq_set,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              start_irq_en,
    input  logic              stop_irq_en,
    input  logic              rd_buf,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] rx_buf,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              start_seen,
    output logic              stop_seen
);
    logic irq_evt;

    // Any event that raises the interrupt flag.
    always_comb irq_evt = irq_set | (start_det & start_irq_en) | (stop_det & stop_irq_en);

    // Flag and buffer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf     <= '0;
            buf_full   <= 1'b0;
            ovf        <= 1'b0;
            irq        <= 1'b0;
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else begin
            if (load) begin
                rx_buf   <= load_val;
                buf_full <= 1'b1;
            end else if (rd_buf) begin
                buf_full <= 1'b0;
            end
            if (ovf_set)
                ovf <= 1'b1;
            else if (ovf_clr)
                ovf <= 1'b0;
            if (irq_evt)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
            if (start_det) begin
                start_seen <= 1'b1;
                stop_seen  <= 1'b0;
            end else if (stop_det) begin
                start_seen <= 1'b0;
                stop_seen  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_tgt_rx.sv
// I2C target write receiver, top level. It ties the line synchronizers,
// the receive engine and the software flags together.
// Assumes clk runs at least 8x the SCL rate and the pins are open-drain.
module i2c_tgt_rx #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              addr_hold_en,
    input  logic              data_hold_en,
    input  logic              start_irq_en,
    input  logic              stop_irq_en,
    input  logic              ack_nack,
    input  logic              rel_set,
    input  logic              rd_buf,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic [ADDR_W:0]   rx_buf,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              ckp,
    output logic              ack_time,
    output logic              start_seen,
    output logic              stop_seen
);
    localparam int BYTE_W = ADDR_W + 1;

    logic scl_s, scl_rise, scl_fall, sda_s, sda_rise, sda_fall;
    logic start_det, stop_det, load, ovf_set, irq_set;
    logic [BYTE_W-1:0] load_val;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in),
        .lvl(scl_s), .rise(scl_rise), .fall(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in),
        .lvl(sda_s), .rise(sda_rise), .fall(sda_fall)
    );

    i2c_rx_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .own_addr(own_addr), .stretch_en(stretch_en),
        .addr_hold_en(addr_hold_en), .data_hold_en(data_hold_en),
        .ack_nack(ack_nack), .rel_set(rel_set),
        .buf_full(buf_full), .ovf(ovf),
        .start_det(start_det), .stop_det(stop_det),
        .load(load), .load_val(load_val), .ovf_set(ovf_set), .irq_set(irq_set),
        .ckp(ckp), .ack_time(ack_time),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low)
    );

    i2c_rx_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .load(load), .load_val(load_val), .ovf_set(ovf_set), .irq_set(irq_set),
        .start_det(start_det), .stop_det(stop_det),
        .start_irq_en(start_irq_en), .stop_irq_en(stop_irq_en),
        .rd_buf(rd_buf), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
        .rx_buf(rx_buf), .buf_full(buf_full), .ovf(ovf), .irq(irq),
        .start_seen(start_seen), .stop_seen(stop_seen)
    );
endmodule

// File: rtl/i2c_tgt_rx_chk.sv
// Property checker for i2c_tgt_rx, bound to every instance of the top.
module i2c_tgt_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_drive_low,
    input logic rel_set,
    input logic rd_buf,
    input logic irq_clr,
    input logic ovf_clr,
    input logic buf_full,
    input logic ovf,
    input logic irq,
    input logic ckp
);
    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !ovf_clr |=> ovf);

    // R6
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(buf_full));

    // R8
    full_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full) |-> $past(rd_buf));

    // R14
    ckp_set_by_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ckp) |-> $past(rel_set));

    // R2
    ack_drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_in);

    // R4
    ack_release_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_low) |-> !scl_in);
endmodule

bind i2c_tgt_rx i2c_tgt_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_drive_low(sda_drive_low),
    .rel_set(rel_set), .rd_buf(rd_buf), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
    .buf_full(buf_full), .ovf(ovf), .irq(irq), .ckp(ckp)
);

// File: tb/i2c_tgt_rx_bench.sv
// Directed bench: a bit-level controller model drives the open-drain bus,
// and software-side tasks work the flags.
module i2c_tgt_rx_bench;
    localparam int Q = 20;
    localparam logic [6:0] ADDR = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [6:0] own_addr = ADDR;
    logic stretch_en = 0, addr_hold_en = 0, data_hold_en = 0;
    logic start_irq_en = 0, stop_irq_en = 0, ack_nack = 0;
    logic rel_set = 0, rd_buf = 0, irq_clr = 0, ovf_clr = 0;
    logic scl_drive_low, sda_drive_low;
    logic [7:0] rx_buf;
    logic buf_full, ovf, irq, ckp, ack_time, start_seen, stop_seen;
    logic scl_bus, sda_bus;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    assign scl_bus = m_scl & ~scl_drive_low;
    assign sda_bus = m_sda & ~sda_drive_low;

    i2c_tgt_rx u_i2c_tgt_rx (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .own_addr(own_addr), .stretch_en(stretch_en),
        .addr_hold_en(addr_hold_en), .data_hold_en(data_hold_en),
        .start_irq_en(start_irq_en), .stop_irq_en(stop_irq_en),
        .ack_nack(ack_nack), .rel_set(rel_set), .rd_buf(rd_buf),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .rx_buf(rx_buf),
        .buf_full(buf_full), .ovf(ovf), .irq(irq), .ckp(ckp),
        .ack_time(ack_time), .start_seen(start_seen), .stop_seen(stop_seen)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic m_bit(input logic b);
        m_sda = b; wq(Q);
        m_scl = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic m_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_bit(v[i]);
    endtask

    task automatic m_ack(output logic got);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
        wq(Q / 2);
        got = ~sda_bus;
        wq(Q / 2);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic sw_read();
        @(negedge clk) rd_buf = 1'b1;
        @(negedge clk) rd_buf = 1'b0;
        @(negedge clk);
    endtask

    task automatic sw_irq_clr();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic sw_ovf_clr();
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic sw_release();
        @(negedge clk) rel_set = 1'b1;
        @(negedge clk) rel_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R14", "ckp after reset", ckp, 1);
        chk("R8", "buf_full after reset", buf_full, 0);
        chk("R7", "irq after reset", irq, 0);
        chk("R6", "ovf after reset", ovf, 0);
        chk("R9", "scl drive after reset", scl_drive_low, 0);
        chk("R2", "sda drive after reset", sda_drive_low, 0);
    endtask

    task automatic t_basic();
        logic a;
        m_start();
        chk("R1", "start_seen", start_seen, 1);
        chk("R1", "stop_seen after start", stop_seen, 0);
        chk("R13", "no irq on start when disabled", irq, 0);
        m_byte({ADDR, 1'b0}); m_ack(a);
        chk("R2", "address ACK", a, 1);
        chk("R2", "address in buffer", rx_buf, {ADDR, 1'b0});
        chk("R2", "buf_full after address", buf_full, 1);
        chk("R4", "irq after address ACK", irq, 1);
        wq(40);
        chk("R7", "irq stays set", irq, 1);
        sw_irq_clr();
        chk("R7", "irq cleared", irq, 0);
        sw_read();
        chk("R8", "read clears buf_full", buf_full, 0);
        chk("R8", "read keeps rx_buf", rx_buf, {ADDR, 1'b0});
        m_byte(8'h3C); m_ack(a);
        chk("R4", "data ACK", a, 1);
        chk("R4", "data in buffer", rx_buf, 8'h3C);
        chk("R4", "irq after data", irq, 1);
        sw_irq_clr(); sw_read();
        m_stop();
        chk("R1", "stop_seen", stop_seen, 1);
        chk("R1", "start_seen after stop", start_seen, 0);
        chk("R13", "no irq on stop when disabled", irq, 0);
    endtask

    task automatic t_overflow();
        logic a;
        m_start();
        m_byte({ADDR, 1'b0}); m_ack(a);
        chk("R2", "address ACK before overflow", a, 1);
        sw_irq_clr();
        m_byte(8'h77); m_ack(a);
        chk("R5", "NACK while full", a, 0);
        chk("R5", "buffer kept", rx_buf, {ADDR, 1'b0});
        chk("R6", "ovf set", ovf, 1);
        chk("R12", "no irq on NACK", irq, 0);
        m_stop();
        sw_read();
        chk("R6", "ovf survives read", ovf, 1);
        sw_ovf_clr();
        chk("R6", "ovf cleared", ovf, 0);
        sw_irq_clr();
    endtask

    task automatic t_mismatch();
        logic a;
        m_start();
        m_byte({7'h11, 1'b0}); m_ack(a);
        chk("R3", "NACK on wrong address", a, 0);
        chk("R3", "no store on wrong address", buf_full, 0);
        chk("R3", "no irq on wrong address", irq, 0);
        m_byte(8'hFF); m_ack(a);
        chk("R3", "later byte ignored", a, 0);
        chk("R3", "later byte not stored", buf_full, 0);
        m_stop();
        m_start();
        m_byte({ADDR, 1'b1}); m_ack(a);
        chk("R3", "NACK on read request", a, 0);
        chk("R3", "no store on read request", buf_full, 0);
        m_stop();
    endtask

    task automatic t_stretch();
        logic a;
        stretch_en = 1'b1;
        m_start();
        m_byte({ADDR, 1'b0}); m_ack(a);
        chk("R9", "address ACK", a, 1);
        chk("R9", "SCL held after ACK", scl_drive_low, 1);
        chk("R9", "ckp cleared", ckp, 0);
        wq(60);
        chk("R9", "bus SCL still low", scl_bus, 0);
        chk("R14", "ckp stays cleared", ckp, 0);
        sw_read(); sw_irq_clr();
        sw_release();
        chk("R14", "ckp set by release", ckp, 1);
        chk("R9", "SCL released", scl_drive_low, 0);
        m_byte(8'h5E); m_ack(a);
        chk("R9", "data ACK", a, 1);
        chk("R9", "SCL held after data ACK", scl_drive_low, 1);
        chk("R4", "data stored", rx_buf, 8'h5E);
        sw_read(); sw_irq_clr(); sw_release();
        m_stop();
        stretch_en = 1'b0;
    endtask

    task automatic t_data_hold();
        logic a;
        data_hold_en = 1'b1;
        m_start();
        m_byte({ADDR, 1'b0}); m_ack(a);
        chk("R10", "address not held", a, 1);
        sw_read(); sw_irq_clr();
        m_byte(8'hA5);
        chk("R10", "irq at 8th edge", irq, 1);
        chk("R10", "ack_time set", ack_time, 1);
        chk("R10", "ckp cleared", ckp, 0);
        chk("R10", "SCL held", scl_drive_low, 1);
        chk("R10", "byte loaded", rx_buf, 8'hA5);
        sw_irq_clr(); sw_read();
        ack_nack = 1'b0;
        sw_release();
        chk("R11", "SCL released", scl_drive_low, 0);
        m_ack(a);
        chk("R11", "software ACK", a, 1);
        chk("R11", "ack_time cleared", ack_time, 0);
        chk("R4", "irq after held ACK", irq, 1);
        sw_irq_clr();
        m_byte(8'h0F);
        chk("R10", "second hold", scl_drive_low, 1);
        sw_irq_clr();
        ack_nack = 1'b1;
        sw_release();
        m_ack(a);
        chk("R11", "software NACK", a, 0);
        chk("R12", "no irq after NACK", irq, 0);
        m_stop();
        sw_read();
        ack_nack = 1'b0;
        data_hold_en = 1'b0;
    endtask

    task automatic t_addr_hold();
        logic a;
        addr_hold_en = 1'b1;
        m_start();
        m_byte({ADDR, 1'b0});
        chk("R10", "address hold irq", irq, 1);
        chk("R10", "address hold ack_time", ack_time, 1);
        chk("R10", "address hold SCL", scl_drive_low, 1);
        chk("R10", "address in buffer", rx_buf, {ADDR, 1'b0});
        sw_read(); sw_irq_clr(); sw_release();
        m_ack(a);
        chk("R11", "address ACK after hold", a, 1);
        sw_irq_clr();
        m_stop();
        addr_hold_en = 1'b0;
    endtask

    task automatic t_cond_irq();
        start_irq_en = 1'b1;
        m_start();
        chk("R13", "irq on start", irq, 1);
        sw_irq_clr();
        start_irq_en = 1'b0;
        stop_irq_en = 1'b1;
        m_stop();
        chk("R13", "irq on stop", irq, 1);
        sw_irq_clr();
        stop_irq_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_basic();
        t_overflow();
        t_mismatch();
        t_stretch();
        t_data_hold();
        t_addr_hold();
        t_cond_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule